// File: doc/BRIEF.md
# Accumulator CPU Control Sequencer

This block is the multi-cycle controller of a small accumulator processor. It does not hold any data. It steps through an instruction cycle and produces the strobes that the datapath needs: load, clear and subtract-select for the accumulator; a load for the instruction register; load and increment for the program counter; a select for the memory address; and a memory write enable.

The cycle starts in a waiting state, which holds until the run input is high. The controller then reads memory at the program counter and latches the word into the instruction register. In the next cycle it advances the program counter. After that comes a decode cycle, where it samples five one-hot class flags that the opcode decoder produces from the instruction register. One execute cycle follows, and then the controller returns to the waiting state. Clearing the run input therefore stops the processor between two instructions.

For a branch-if-zero, the memory address still comes from the program counter, which now points at the branch-target word. If the accumulator is zero, the program counter loads that word. Otherwise it steps past it.

Top module: `acc_ctrl_seq`

## Requirements
- R1: A synchronous active-high reset puts the controller in the waiting state. In the first cycle after the reset edge, every strobe is 0, and this holds even when reset arrives in the middle of an instruction.
- R2: In the waiting state every strobe is 0. The controller stays there for every cycle in which `run_en` is low at the clock edge.
- R3: In the cycle after the controller leaves the waiting state, only `ir_load` is 1. `addr_from_ir` and `mem_write` are 0 in that cycle, so the instruction register takes a read at the program counter address.
- R4: In the next cycle only `pc_step` is 1. In the cycle after that (decode), all strobes are 0, and `instr_cls` is sampled at the end of it.
- R5: Add class (`instr_cls` bit 0): the execute cycle asserts `acc_load` and `addr_from_ir`, with `acc_sub` at 0.
- R6: Subtract class (bit 1): the execute cycle asserts `acc_load`, `addr_from_ir` and `acc_sub`.
- R7: Clear class (bit 2): the execute cycle asserts only `acc_clear`.
- R8: Store class (bit 3): the execute cycle asserts `addr_from_ir` and `mem_write`, for exactly one cycle.
- R9: Branch-if-zero class (bit 4): the execute cycle has `addr_from_ir` at 0. It asserts `pc_load` if `acc_zero` is 1, and otherwise asserts `pc_step`.
- R10: If more than one flag is set at decode, the lowest-numbered set bit wins. If no flag is set, the controller goes straight back to the waiting state without an execute cycle.
- R11: After the execute cycle the controller is in the waiting state, and it stays there if `run_en` is low.
- R12: `mem_write` is never 1 while `addr_from_ir` is 0, and `pc_load` and `pc_step` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run switch, sampled only in the waiting state |
| instr_cls | input | 5 | One-hot class flags: add, subtract, clear, store, branch-if-zero (bits 0 to 4) |
| acc_zero | input | 1 | Accumulator equals zero |
| acc_sub | output | 1 | Adder subtracts when 1 |
| acc_load | output | 1 | Accumulator loads the adder result |
| acc_clear | output | 1 | Accumulator clears to zero |
| ir_load | output | 1 | Instruction register loads the memory word |
| pc_load | output | 1 | Program counter loads a 4-bit value from memory |
| pc_step | output | 1 | Program counter increments by one |
| addr_from_ir | output | 1 | Memory address comes from the IR (1) or the PC (0) |
| mem_write | output | 1 | Memory write (1) or read (0) |

## Verification
A state register that is corrupted shows at the strobes in the same cycle, because every strobe except the branch pair is a function of the state alone. A skipped or repeated phase changes the count of `ir_load` and `pc_step` pulses within five cycles of leaving the waiting state. A wrong latched operation shows only in the execute cycle, four cycles after `run_en` is sampled, as the wrong strobe combination. Such errors then spread into the datapath: a short program run with a behavioural datapath ends with the wrong accumulator, stored word or program counter.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int NUM_CLS = 5;
    localparam int OP_W    = $clog2(NUM_CLS + 1);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_STEP   = 3'd2,
        ST_DECODE = 3'd3,
        ST_EXEC   = 3'd4
    } seq_state_t;

    // class index order fixes the priority: lower index wins
    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_CLR   = 3'd2,
        OP_STORE = 3'd3,
        OP_BZ    = 3'd4,
        OP_NONE  = 3'd5
    } op_sel_t;

    typedef struct packed {
        logic acc_sub;
        logic acc_load;
        logic acc_clear;
        logic ir_load;
        logic pc_load;
        logic pc_step;
        logic addr_from_ir;
        logic mem_write;
    } ctrl_t;

    function automatic op_sel_t pick_op(input logic [NUM_CLS-1:0] flags);
        op_sel_t sel;
        sel = OP_NONE;
        for (int i = NUM_CLS - 1; i >= 0; i--) begin
            if (flags[i]) sel = op_sel_t'(i[OP_W-1:0]);
        end
        return sel;
    endfunction

endpackage

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
    import acc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic [NUM_CLS-1:0] instr_cls,
    output seq_state_t         state_q,
    output op_sel_t            op_q
);
    seq_state_t state_d;
    op_sel_t    op_d;
    op_sel_t    op_pick;

    assign op_pick = pick_op(instr_cls);

    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        unique case (state_q)
            ST_IDLE:   if (run_en) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_STEP;
            ST_STEP:   state_d = ST_DECODE;
            ST_DECODE: begin
                op_d    = op_pick;
                state_d = (op_pick == OP_NONE) ? ST_IDLE : ST_EXEC;
            end
            ST_EXEC:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
        end
    end
endmodule

// File: rtl/acc_seq_strobe.sv
module acc_seq_strobe
    import acc_seq_pkg::*;
(
    input  seq_state_t state_q,
    input  op_sel_t    op_q,
    input  logic       acc_zero,
    output ctrl_t      ctl
);
    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_FETCH: ctl.ir_load = 1'b1;
            ST_STEP:  ctl.pc_step = 1'b1;
            ST_EXEC: begin
                unique case (op_q)
                    OP_ADD: begin
                        ctl.acc_load     = 1'b1;
                        ctl.addr_from_ir = 1'b1;
                    end
                    OP_SUB: begin
                        ctl.acc_load     = 1'b1;
                        ctl.acc_sub      = 1'b1;
                        ctl.addr_from_ir = 1'b1;
                    end
                    OP_CLR:   ctl.acc_clear = 1'b1;
                    OP_STORE: begin
                        ctl.addr_from_ir = 1'b1;
                        ctl.mem_write    = 1'b1;
                    end
                    OP_BZ: begin
                        ctl.pc_load = acc_zero;
                        ctl.pc_step = ~acc_zero;
                    end
                    default: ctl = '0;
                endcase
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/acc_ctrl_seq.sv
module acc_ctrl_seq
    import acc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic [NUM_CLS-1:0] instr_cls,
    input  logic               acc_zero,
    output logic               acc_sub,
    output logic               acc_load,
    output logic               acc_clear,
    output logic               ir_load,
    output logic               pc_load,
    output logic               pc_step,
    output logic               addr_from_ir,
    output logic               mem_write
);
    seq_state_t state_q;
    op_sel_t    op_q;
    ctrl_t      ctl;

    acc_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .instr_cls (instr_cls),
        .state_q   (state_q),
        .op_q      (op_q)
    );

    acc_seq_strobe u_strobe (
        .state_q  (state_q),
        .op_q     (op_q),
        .acc_zero (acc_zero),
        .ctl      (ctl)
    );

    assign acc_sub      = ctl.acc_sub;
    assign acc_load     = ctl.acc_load;
    assign acc_clear    = ctl.acc_clear;
    assign ir_load      = ctl.ir_load;
    assign pc_load      = ctl.pc_load;
    assign pc_step      = ctl.pc_step;
    assign addr_from_ir = ctl.addr_from_ir;
    assign mem_write    = ctl.mem_write;
endmodule

// File: rtl/acc_ctrl_seq_chk.sv
module acc_ctrl_seq_chk
    import acc_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       run_en,
    input seq_state_t state_q,
    input logic       acc_sub,
    input logic       acc_load,
    input logic       acc_clear,
    input logic       ir_load,
    input logic       pc_load,
    input logic       pc_step,
    input logic       addr_from_ir,
    input logic       mem_write
);
    logic [7:0] strobes;
    assign strobes = {acc_sub, acc_load, acc_clear, ir_load,
                      pc_load, pc_step, addr_from_ir, mem_write};

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (strobes == 8'd0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !run_en) |=> (state_q == ST_IDLE && strobes == 8'd0));

    // R4
    fetch_then_step_chk: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (pc_step && !ir_load));

    // R6
    sub_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
        acc_sub |-> (acc_load && addr_from_ir));

    // R8
    store_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_write |=> !mem_write);

    // R12
    write_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_write |-> addr_from_ir);

    // R12
    pc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({pc_load, pc_step}) <= 1);
endmodule

bind acc_ctrl_seq acc_ctrl_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .run_en       (run_en),
    .state_q      (state_q),
    .acc_sub      (acc_sub),
    .acc_load     (acc_load),
    .acc_clear    (acc_clear),
    .ir_load      (ir_load),
    .pc_load      (pc_load),
    .pc_step      (pc_step),
    .addr_from_ir (addr_from_ir),
    .mem_write    (mem_write)
);

// File: tb/tb_acc_ctrl_seq.sv
module tb_acc_ctrl_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0;
    logic [4:0] cls_drv = '0;
    logic zero_drv = 1'b0;
    logic model_on = 1'b0;
    logic [4:0] instr_cls;
    logic acc_zero;
    logic acc_sub, acc_load, acc_clear, ir_load, pc_load, pc_step, addr_from_ir, mem_write;

    int checks = 0;
    int fails = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    // behavioural datapath
    logic [3:0] pc;
    logic [7:0] ir, acc;
    logic [7:0] mem [16];
    logic [3:0] maddr;
    logic [4:0] model_cls;

    function automatic logic [7:0] rom(input int a);
        case (a)
            0: return 8'h30;   // clear
            1: return 8'h1E;   // add [14]
            2: return 8'h2E;   // sub [14]
            3: return 8'h50;   // branch if zero
            4: return 8'h07;   // target
            5: return 8'h1E;
            6: return 8'h1E;
            7: return 8'h1F;   // add [15]
            8: return 8'h50;   // branch if zero (not taken)
            9: return 8'h00;   // target
            10: return 8'h4D;  // store [13]
            14: return 8'h05;
            15: return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    assign maddr = addr_from_ir ? ir[3:0] : pc;
    always_comb begin
        model_cls = '0;
        case (ir[7:4])
            4'd1: model_cls = 5'b00001;
            4'd2: model_cls = 5'b00010;
            4'd3: model_cls = 5'b00100;
            4'd4: model_cls = 5'b01000;
            4'd5: model_cls = 5'b10000;
            default: model_cls = '0;
        endcase
    end
    assign instr_cls = model_on ? model_cls : cls_drv;
    assign acc_zero  = model_on ? (acc == 8'd0) : zero_drv;

    always @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            ir  <= '0;
            acc <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= rom(i);
        end else begin
            if (ir_load) ir <= mem[maddr];
            if (pc_load) pc <= mem[maddr][3:0];
            else if (pc_step) pc <= pc + 4'd1;
            if (acc_clear) acc <= '0;
            else if (acc_load) acc <= acc_sub ? acc - mem[maddr] : acc + mem[maddr];
            if (mem_write) mem[maddr] <= acc;
        end
    end

    acc_ctrl_seq dut (
        .clk(clk), .rst(rst), .run_en(run_en), .instr_cls(instr_cls), .acc_zero(acc_zero),
        .acc_sub(acc_sub), .acc_load(acc_load), .acc_clear(acc_clear), .ir_load(ir_load),
        .pc_load(pc_load), .pc_step(pc_step), .addr_from_ir(addr_from_ir), .mem_write(mem_write)
    );

    // {acc_sub, acc_load, acc_clear, ir_load, pc_load, pc_step, addr_from_ir, mem_write}
    localparam logic [7:0] V_IRLD = 8'b0001_0000;
    localparam logic [7:0] V_STEP = 8'b0000_0100;

    function automatic logic [7:0] outs();
        return {acc_sub, acc_load, acc_clear, ir_load, pc_load, pc_step, addr_from_ir, mem_write};
    endfunction

    function automatic logic [7:0] exp_exec(input logic [4:0] f, input logic z);
        if (f[0]) return 8'b0100_0010;
        if (f[1]) return 8'b1100_0010;
        if (f[2]) return 8'b0010_0000;
        if (f[3]) return 8'b0000_0011;
        if (f[4]) return z ? 8'b0000_1000 : 8'b0000_0100;
        return 8'b0000_0000;
    endfunction

    function automatic string exec_tag(input logic [4:0] f);
        if ($countones(f) > 1) return "R10 priority";
        if (f[0]) return "R5 add";
        if (f[1]) return "R6 sub";
        if (f[2]) return "R7 clear";
        if (f[3]) return "R8 store";
        if (f[4]) return "R9 branch";
        return "R10 none";
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(outs(), 8'd0, "R1 reset state");
        @(negedge clk);
        check(outs(), 8'd0, "R2 idle with run low");

        // sweep every flag pattern and zero value
        for (int f = 0; f < 32; f++) begin
            for (int z = 0; z < 2; z++) begin
                run_en = 1'b1;
                cls_drv = f[4:0];
                zero_drv = z[0];
                check(outs(), 8'd0, "R2 idle before start");
                @(negedge clk);
                run_en = 1'b0;
                check(outs(), V_IRLD, "R3 fetch");
                @(negedge clk);
                check(outs(), V_STEP, "R4 step");
                @(negedge clk);
                check(outs(), 8'd0, "R4 decode");
                @(negedge clk);
                check(outs(), exp_exec(f[4:0], z[0]), exec_tag(f[4:0]));
                @(negedge clk);
                check(outs(), 8'd0, "R11 back to idle");
                @(negedge clk);
            end
        end

        // reset in the middle of an instruction
        cls_drv = 5'b00001;
        run_en = 1'b1;
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(outs(), 8'd0, "R1 mid-instruction reset");
        rst = 1'b0;
        @(negedge clk);
        check(outs(), 8'd0, "R1 idle after reset");

        // program run on the behavioural datapath
        rst = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_en = 1'b1;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (pc == 4'd11) break;
        end
        run_en = 1'b0;
        repeat (6) @(negedge clk);
        check(acc, 8'd3, "R9 program accumulator");
        check(mem[13], 8'd3, "R8 program stored word");
        check({4'd0, pc}, 8'd11, "R11 program halt pc");
        check(outs(), 8'd0, "R11 halted idle");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule